// File: doc/BRIEF.md
# Sequential Vector Branch Condition Evaluator

This block reduces a vector of 4-bit condition fields to one branch decision by visiting one element per clock. A start pulse captures the vector length, the per-element predicate mask, the first field number, the bit selector, the count register and all mode bits. The block then drives a field index out on its read port and receives that field back in the same cycle. It tests one bit of the field, or a stand-in value for an element that the predicate masks off. It folds the result into an AND or OR accumulator and stops at the first element that settles the outcome.

Along the walk the block may decrement the count register, depending on the test outcome and the count-test options. It may also propose a truncated vector length. When the walk ends, it reports branch-taken, the final count, the optional new length and the link-update enable, all with a one-cycle done pulse. Target address arithmetic, decode and register storage stay outside. Start and done form a plain command/response pair with no back-pressure: a start that arrives while a walk is running is dropped, and the result stays on the outputs until the next accepted walk completes.

Top module: `vbranch_eval`

## Requirements
- R1: Element k reads field number (base + k) mod 128, or field number base for every element when the scalar flag is set. Within a field, bit 3 is LT, bit 2 GT, bit 1 EQ and bit 0 SO, and selector values 0, 1, 2 and 3 pick LT, GT, EQ and SO.
- R2: When an element's predicate bit (bit k of the mask) is 0 and zeroing (sz) is 1, the tested bit is SNZ instead of the field bit. When the predicate bit is 0 and sz is 0, the element is skipped: it is not tested and does not touch the accumulator.
- R3: With bo[0] = force-true, bo[1] = wanted bit value, bo[2] = ignore-count and bo[3] = count-zero sense, the element condition is bo[0] | (testbit == bo[1]) and the count check is bo[2] | ((count != 0) ^ bo[3]). The count check uses the count before this element's decrement. In 32-bit mode only the low 32 bits of the count are compared with zero.
- R4: A tested element decrements the count by one when bo[2] = 0, except when count-test is on and (condition XOR CTi) = 1.
- R5: A skipped element decrements the count only when bo[2] = 0, count-test is on and CTi = 0. Otherwise the count is unchanged.
- R6: The element result is condition AND count check. The accumulator starts at the ALL bit, takes the AND of the results when ALL = 1 and the OR when ALL = 0, and its final value is branch-taken.
- R7: The walk ends at the first element whose result differs from ALL. No later element is read or changes the count, and done rises N cycles after the start cycle, where N is the number of elements visited (tested or skipped).
- R8: With VLSET on, a tested element whose result equals VSb ends the walk and raises new-VL-valid. The new VL is the step index plus 1 when VLI = 1, or the step index when VLI = 0. Otherwise new-VL-valid is 0 and the new VL reads 0.
- R9: With VL = 0, no element is read, done rises one cycle after start, and the branch is taken exactly when ALL = 1.
- R10: With the scalar flag set, the walk ends after the first tested element, and skipped elements before it are still counted as visited.
- R11: The link enable equals LK when the branch is not taken and LK XOR LRu when it is taken.
- R12: After reset all outputs are 0. done is high for exactly one cycle per walk, start is ignored while busy, and the results hold until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (sampled when idle) |
| vl_i | input | 7 | Vector length, 0 to 127 |
| pred_i | input | 128 | Predicate mask, bit k for element k |
| cf_base_i | input | 7 | Field number of element 0 |
| bit_sel_i | input | 2 | Bit selector within a field |
| rd_idx_o | output | 7 | Field number being read |
| rd_field_i | input | 4 | Field contents for rd_idx_o, same cycle |
| bo_i | input | 4 | Branch option bits (see R3) |
| all_i | input | 1 | 1 = AND of all results, 0 = OR |
| sz_i | input | 1 | Substitute instead of skip for masked elements |
| snz_i | input | 1 | Substitute value |
| ctrtest_i | input | 1 | Count-test mode |
| cti_i | input | 1 | Count-test inversion |
| vlset_i | input | 1 | Enable length truncation |
| vsb_i | input | 1 | Result value that triggers truncation |
| vli_i | input | 1 | Truncation includes the current element |
| lk_i | input | 1 | Link request |
| lru_i | input | 1 | Make link conditional on the outcome |
| scalar_i | input | 1 | Condition operand is scalar |
| mode64_i | input | 1 | 1 = 64-bit count compare, 0 = 32-bit |
| ctr_i | input | 64 | Count register value at start |
| busy_o | output | 1 | Walk in progress |
| taken_o | output | 1 | Branch decision |
| ctr_o | output | 64 | Final count register |
| vl_new_valid_o | output | 1 | A truncated length is proposed |
| vl_new_o | output | 7 | Proposed length |
| link_o | output | 1 | Link-update enable |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that rd_field_i returns the field addressed by rd_idx_o in the same cycle and that start_i is a clean synchronous level. Apart from that, they relate only values the block captures at start to its later outputs. The bench meets these assumptions by modelling the field store as a combinational array indexed by rd_idx_o and by changing every input, start included, only on the falling clock edge. It mixes swept random configurations with short vectors, small counts near zero and count values whose upper half alone is non-zero, so that every early-exit and decrement path is reached without leaving those assumptions.

// File: rtl/vbe_pkg.sv
package vbe_pkg;
  localparam int CF_W = 4;

  typedef struct packed {
    logic [3:0] bo;
    logic       all;
    logic       sz;
    logic       snz;
    logic       ctrtest;
    logic       cti;
    logic       vlset;
    logic       vsb;
    logic       vli;
    logic       lk;
    logic       lru;
    logic       scalar;
    logic       mode64;
    logic [1:0] sel;
  } vbe_ctrl_t;
endpackage

// File: rtl/vbe_elem.sv
// Combinational evaluation of one element: skip, decrement and result.
module vbe_elem
  import vbe_pkg::*;
#(
  parameter int CTR_W = 64
) (
  input  vbe_ctrl_t        ctrl,
  input  logic             pbit,
  input  logic [CF_W-1:0]  field,
  input  logic [CTR_W-1:0] ctr,
  output logic             skip,
  output logic             dec,
  output logic             res
);
  localparam int HALF = CTR_W / 2;

  // field bit 3 is selector 0: build the reversed view once
  logic [CF_W-1:0] rev;
  for (genvar g = 0; g < CF_W; g++) begin : g_rev
    assign rev[g] = field[CF_W-1-g];
  end

  logic testbit, cond, nz, cok;

  always_comb begin
    skip    = !pbit && !ctrl.sz;
    testbit = pbit ? rev[ctrl.sel] : ctrl.snz;
    cond    = ctrl.bo[0] | (testbit == ctrl.bo[1]);
    nz      = ctrl.mode64 ? (ctr != '0) : (ctr[HALF-1:0] != '0);
    cok     = ctrl.bo[2] | (nz ^ ctrl.bo[3]);
    res     = cond & cok;
    if (skip) dec = !ctrl.bo[2] && ctrl.ctrtest && !ctrl.cti;
    else      dec = !ctrl.bo[2] && !(ctrl.ctrtest && (cond ^ ctrl.cti));
  end
endmodule

// File: rtl/vbe_seq.sv
// Walk sequencer: captures the command, steps elements, registers results.
module vbe_seq
  import vbe_pkg::*;
#(
  parameter int MAX_VL = 128,
  parameter int CTR_W  = 64,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] vl_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic [IDX_W-1:0] base_i,
  input  vbe_ctrl_t        ctrl_i,
  input  logic [CTR_W-1:0] ctr_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output vbe_ctrl_t        ctrl_q_o,
  output logic             pbit_o,
  output logic [CTR_W-1:0] ctr_cur_o,
  input  logic             skip_i,
  input  logic             dec_i,
  input  logic             res_i,
  output logic             busy_o,
  output logic             taken_o,
  output logic [CTR_W-1:0] ctr_o,
  output logic             vv_o,
  output logic [IDX_W-1:0] vn_o,
  output logic             link_o,
  output logic             done_o,
  output logic [IDX_W-1:0] vl_lat_o,
  output logic [IDX_W-1:0] base_lat_o
);
  localparam logic [CTR_W-1:0] ONE = {{(CTR_W-1){1'b0}}, 1'b1};

  vbe_ctrl_t         c_q;
  logic [MAX_VL-1:0] pred_q;
  logic [IDX_W-1:0]  vl_q, base_q, step_q, step_inc;
  logic [CTR_W-1:0]  ctr_q, ctr_n;
  logic              busy_q, acc_q, acc_n, trunc, stop, last;

  assign step_inc   = step_q + IDX_W'(1);
  assign rd_idx_o   = c_q.scalar ? base_q : base_q + step_q;
  assign pbit_o     = pred_q[step_q];
  assign ctr_cur_o  = ctr_q;
  assign ctrl_q_o   = c_q;
  assign busy_o     = busy_q;
  assign vl_lat_o   = vl_q;
  assign base_lat_o = base_q;

  always_comb begin
    last  = (step_inc == vl_q);
    ctr_n = ctr_q;
    acc_n = acc_q;
    trunc = 1'b0;
    stop  = 1'b0;
    if (vl_q == '0) begin
      stop = 1'b1;
    end else begin
      if (dec_i) ctr_n = ctr_q - ONE;
      if (skip_i) begin
        stop = last;
      end else begin
        acc_n = c_q.all ? (acc_q & res_i) : (acc_q | res_i);
        trunc = c_q.vlset && (c_q.vsb == res_i);
        stop  = trunc || (res_i != c_q.all) || c_q.scalar || last;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= '0; pred_q <= '0; vl_q <= '0; base_q <= '0; step_q <= '0;
      ctr_q <= '0; busy_q <= 1'b0; acc_q <= 1'b0;
      taken_o <= 1'b0; ctr_o <= '0; vv_o <= 1'b0; vn_o <= '0;
      link_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          c_q    <= ctrl_i;
          pred_q <= pred_i;
          vl_q   <= vl_i;
          base_q <= base_i;
          ctr_q  <= ctr_i;
          acc_q  <= ctrl_i.all;
          step_q <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        ctr_q  <= ctr_n;
        acc_q  <= acc_n;
        step_q <= step_inc;
        if (stop) begin
          busy_q  <= 1'b0;
          done_o  <= 1'b1;
          taken_o <= acc_n;
          ctr_o   <= ctr_n;
          vv_o    <= trunc;
          vn_o    <= trunc ? (c_q.vli ? step_inc : step_q) : '0;
          link_o  <= c_q.lk ^ (c_q.lru & acc_n);
        end
      end
    end
  end
endmodule

// File: rtl/vbranch_eval.sv
module vbranch_eval
  import vbe_pkg::*;
#(
  parameter int MAX_VL = 128,
  parameter int CTR_W  = 64,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  vl_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic [IDX_W-1:0]  cf_base_i,
  input  logic [1:0]        bit_sel_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [CF_W-1:0]   rd_field_i,
  input  logic [3:0]        bo_i,
  input  logic              all_i,
  input  logic              sz_i,
  input  logic              snz_i,
  input  logic              ctrtest_i,
  input  logic              cti_i,
  input  logic              vlset_i,
  input  logic              vsb_i,
  input  logic              vli_i,
  input  logic              lk_i,
  input  logic              lru_i,
  input  logic              scalar_i,
  input  logic              mode64_i,
  input  logic [CTR_W-1:0]  ctr_i,
  output logic              busy_o,
  output logic              taken_o,
  output logic [CTR_W-1:0]  ctr_o,
  output logic              vl_new_valid_o,
  output logic [IDX_W-1:0]  vl_new_o,
  output logic              link_o,
  output logic              done_o
);
  vbe_ctrl_t        ctrl_in, ctrl_q;
  logic             pbit, skip, dec, res;
  logic [CTR_W-1:0] ctr_work;
  logic [IDX_W-1:0] vl_lat, base_lat;

  always_comb begin
    ctrl_in.bo      = bo_i;
    ctrl_in.all     = all_i;
    ctrl_in.sz      = sz_i;
    ctrl_in.snz     = snz_i;
    ctrl_in.ctrtest = ctrtest_i;
    ctrl_in.cti     = cti_i;
    ctrl_in.vlset   = vlset_i;
    ctrl_in.vsb     = vsb_i;
    ctrl_in.vli     = vli_i;
    ctrl_in.lk      = lk_i;
    ctrl_in.lru     = lru_i;
    ctrl_in.scalar  = scalar_i;
    ctrl_in.mode64  = mode64_i;
    ctrl_in.sel     = bit_sel_i;
  end

  vbe_elem #(.CTR_W(CTR_W)) u_elem (
    .ctrl(ctrl_q), .pbit(pbit), .field(rd_field_i), .ctr(ctr_work),
    .skip(skip), .dec(dec), .res(res)
  );

  vbe_seq #(.MAX_VL(MAX_VL), .CTR_W(CTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .pred_i(pred_i),
    .base_i(cf_base_i), .ctrl_i(ctrl_in), .ctr_i(ctr_i), .rd_idx_o(rd_idx_o),
    .ctrl_q_o(ctrl_q), .pbit_o(pbit), .ctr_cur_o(ctr_work),
    .skip_i(skip), .dec_i(dec), .res_i(res), .busy_o(busy_o),
    .taken_o(taken_o), .ctr_o(ctr_o), .vv_o(vl_new_valid_o), .vn_o(vl_new_o),
    .link_o(link_o), .done_o(done_o), .vl_lat_o(vl_lat), .base_lat_o(base_lat)
  );
endmodule

// File: rtl/vbranch_eval_chk.sv
module vbranch_eval_chk #(
  parameter int CTR_W = 64,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             taken_o,
  input logic [CTR_W-1:0] ctr_o,
  input logic             link_o,
  input logic             vl_new_valid_o,
  input logic [IDX_W-1:0] vl_new_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic [CTR_W-1:0] ctr_work,
  input logic             lk_lat,
  input logic             scalar_lat,
  input logic [IDX_W-1:0] base_lat,
  input logic [IDX_W-1:0] vl_lat
);
  localparam logic [CTR_W-1:0] ONE = {{(CTR_W-1){1'b0}}, 1'b1};

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(taken_o) && $stable(ctr_o) && $stable(link_o)
                 && $stable(vl_new_valid_o) && $stable(vl_new_o)));

  // R4
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |->
      (ctr_work == $past(ctr_work) || ctr_work == $past(ctr_work) - ONE));

  // R11
  link_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !taken_o) |-> (link_o == lk_lat));

  // R8
  vl_new_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && vl_new_valid_o) |-> (vl_new_o <= vl_lat));

  // R1
  scalar_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && scalar_lat) |-> (rd_idx_o == base_lat));
endmodule

bind vbranch_eval vbranch_eval_chk #(.CTR_W(CTR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .taken_o(taken_o), .ctr_o(ctr_o), .link_o(link_o),
  .vl_new_valid_o(vl_new_valid_o), .vl_new_o(vl_new_o), .rd_idx_o(rd_idx_o),
  .ctr_work(ctr_work), .lk_lat(ctrl_q.lk), .scalar_lat(ctrl_q.scalar),
  .base_lat(base_lat), .vl_lat(vl_lat)
);

// File: tb/vbranch_eval_test.sv
module vbranch_eval_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         start;
  logic [6:0]   t_vl, t_base, rd_idx, vl_new;
  logic [127:0] t_pred;
  logic [1:0]   t_sel;
  logic [3:0]   t_bo, rd_field;
  logic t_all, t_sz, t_snz, t_ctt, t_cti, t_vls, t_vsb, t_vli, t_lk, t_lru, t_scal, t_m64;
  logic [63:0]  t_ctr, ctr_out;
  logic busy, taken, vv, link, done;
  logic [3:0]   mem [128];

  assign rd_field = mem[rd_idx];

  vbranch_eval uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vl_i(t_vl), .pred_i(t_pred),
    .cf_base_i(t_base), .bit_sel_i(t_sel), .rd_idx_o(rd_idx), .rd_field_i(rd_field),
    .bo_i(t_bo), .all_i(t_all), .sz_i(t_sz), .snz_i(t_snz), .ctrtest_i(t_ctt),
    .cti_i(t_cti), .vlset_i(t_vls), .vsb_i(t_vsb), .vli_i(t_vli), .lk_i(t_lk),
    .lru_i(t_lru), .scalar_i(t_scal), .mode64_i(t_m64), .ctr_i(t_ctr),
    .busy_o(busy), .taken_o(taken), .ctr_o(ctr_out), .vl_new_valid_o(vv),
    .vl_new_o(vl_new), .link_o(link), .done_o(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5679;

  task automatic rnd(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected values from the requirements
  logic        e_taken, e_vv, e_link;
  logic [63:0] e_ctr;
  logic [6:0]  e_vn;
  int          e_cyc;

  task automatic model();
    logic acc, p, tb, cond, nz, cok, r;
    logic [63:0] c;
    logic [6:0] idx;
    acc = t_all; c = t_ctr; e_vv = 0; e_vn = 0; e_cyc = 0;
    if (t_vl == 0) e_cyc = 1;
    for (int s = 0; s < int'(t_vl); s++) begin
      e_cyc++;
      p = t_pred[s];
      idx = t_scal ? t_base : 7'(int'(t_base) + s);
      if (!p && !t_sz) begin
        if (!t_bo[2] && t_ctt && !t_cti) c = c - 1;
        continue;
      end
      tb   = p ? mem[idx][3 - int'(t_sel)] : t_snz;
      cond = t_bo[0] | (tb == t_bo[1]);
      nz   = t_m64 ? (c != 0) : (c[31:0] != 0);
      cok  = t_bo[2] | (nz ^ t_bo[3]);
      r    = cond & cok;
      if (!t_bo[2] && !(t_ctt && (cond ^ t_cti))) c = c - 1;
      acc = t_all ? (acc & r) : (acc | r);
      if (t_vls && (t_vsb == r)) begin
        e_vv = 1; e_vn = t_vli ? 7'(s + 1) : 7'(s);
        break;
      end
      if (r != t_all) break;
      if (t_scal) break;
    end
    e_taken = acc; e_ctr = c; e_link = t_lk ^ (t_lru & acc);
  endtask

  int a_cyc;

  task automatic launch_wait();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_cyc = 0;
    do begin
      @(negedge clk);
      a_cyc++;
    end while (!done && a_cyc < 400);
  endtask

  task automatic run();
    model();
    @(negedge clk);
    launch_wait();
    chk("R6", "taken", 64'(taken), 64'(e_taken));
    chk("R4", "count", ctr_out, e_ctr);
    chk("R8", "vl_valid", 64'(vv), 64'(e_vv));
    chk("R8", "vl_new", 64'(vl_new), 64'(e_vn));
    chk("R11", "link", 64'(link), 64'(e_link));
    chk("R7", "cycles", 64'(a_cyc), 64'(e_cyc));
  endtask

  task automatic defaults();
    t_vl = 0; t_pred = '1; t_base = 0; t_sel = 0; t_bo = 0; t_all = 0; t_sz = 0;
    t_snz = 0; t_ctt = 0; t_cti = 0; t_vls = 0; t_vsb = 0; t_vli = 0; t_lk = 0;
    t_lru = 0; t_scal = 0; t_m64 = 1; t_ctr = 0;
  endtask

  task automatic rand_cfg();
    logic [31:0] r, a, b, c, d;
    rnd(r);
    t_bo = r[3:0]; t_all = r[4]; t_sz = r[5]; t_snz = r[6]; t_ctt = r[7];
    t_cti = r[8]; t_vls = r[9]; t_vsb = r[10]; t_vli = r[11]; t_lk = r[12];
    t_lru = r[13]; t_scal = (r[16:14] == 0); t_m64 = r[17]; t_sel = r[19:18];
    rnd(a);
    t_vl = (r[23:20] == 0) ? a[6:0] : 7'(a[7:0] % 9);
    rnd(b);
    t_base = b[6:0];
    t_ctr = {(r[24] ? b : 32'h0), 32'(a[31:29] % 4)};
    rnd(a); rnd(b); rnd(c); rnd(d);
    t_pred = {a, b, c, d};
    if (r[25]) t_pred = '1;
  endtask

  task automatic fill_mem();
    logic [31:0] v;
    for (int i = 0; i < 128; i++) begin
      rnd(v);
      mem[i] = v[3:0];
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    start = 1'b0;
    defaults();
    fill_mem();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "reset taken", 64'(taken), 0);
    chk("R12", "reset count", ctr_out, 0);
    chk("R12", "reset done/busy", 64'({done, busy, vv, link}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: field walk wraps past 127; EQ selected (bit 1)
    defaults();
    for (int i = 0; i < 128; i++) mem[i] = 4'b0010;
    t_vl = 4; t_base = 126; t_sel = 2; t_bo = 4'b0110; t_all = 1;
    run();
    chk("R1", "all fields match", 64'(taken), 1);
    mem[0] = 4'b1101;
    run();
    chk("R1", "wrapped field 0 fails", 64'(taken), 0);
    chk("R1", "exit at third element", 64'(a_cyc), 3);
    mem[0] = 4'b0010;
    t_sel = 0; mem[127] = 4'b1000; t_bo = 4'b0110; t_vl = 1; t_base = 127;
    run();
    chk("R1", "LT is field bit 3", 64'(taken), 1);

    // R2: masked element substitution and skipping
    defaults();
    for (int i = 0; i < 128; i++) mem[i] = 4'b0010;
    t_vl = 4; t_sel = 2; t_bo = 4'b0110; t_all = 1; t_pred = ~128'h2; t_sz = 1;
    t_snz = 0;
    run();
    chk("R2", "snz=0 fails element 1", 64'(a_cyc), 2);
    t_snz = 1;
    run();
    chk("R2", "snz=1 passes", 64'(taken), 1);
    t_sz = 0; t_snz = 0;
    run();
    chk("R2", "skip leaves result", 64'(taken), 1);

    // R3: 32-bit mode compares low half only
    defaults();
    t_vl = 1; t_bo = 4'b0001; t_ctr = 64'h1_0000_0000; t_m64 = 0;
    run();
    chk("R3", "32-bit count zero", 64'(taken), 0);
    t_m64 = 1;
    run();
    chk("R3", "64-bit count nonzero", 64'(taken), 1);

    // R5: skipped-element decrement
    defaults();
    t_vl = 3; t_pred = '0; t_ctt = 1; t_cti = 0; t_ctr = 10;
    run();
    chk("R5", "skips decrement", ctr_out, 7);
    t_cti = 1;
    run();
    chk("R5", "skips hold count", ctr_out, 10);

    // R9: empty vector
    defaults();
    t_all = 1;
    run();
    chk("R9", "VL=0 AND taken", 64'(taken), 1);
    t_all = 0;
    run();
    chk("R9", "VL=0 OR not taken", 64'(taken), 0);
    chk("R9", "VL=0 one cycle", 64'(a_cyc), 1);

    // R10: scalar operand stops after first tested element
    defaults();
    t_vl = 5; t_pred = 128'b11100; t_bo = 4'b0101; t_all = 1; t_scal = 1;
    run();
    chk("R10", "scalar visits three", 64'(a_cyc), 3);
    chk("R10", "scalar taken", 64'(taken), 1);

    // R8: truncation with skipped elements before the failure
    defaults();
    for (int i = 0; i < 128; i++) mem[i] = 4'b0010;
    mem[4] = 4'b0000;
    t_vl = 6; t_pred = 128'b110010; t_sel = 2; t_bo = 4'b0110; t_all = 1;
    t_vls = 1; t_vsb = 0; t_vli = 0;
    run();
    chk("R8", "exclusive length", 64'(vl_new), 4);
    t_vli = 1;
    run();
    chk("R8", "inclusive length", 64'(vl_new), 5);

    // R11: conditional link
    defaults();
    t_vl = 1; t_bo = 4'b0101; t_lk = 1; t_lru = 1;
    run();
    chk("R11", "taken inverts link", 64'(link), 0);

    // R12: start ignored while busy, outputs hold
    defaults();
    t_vl = 6; t_bo = 4'b0101; t_all = 1; t_ctr = 20;
    model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_cyc = 0;
    @(negedge clk); a_cyc++;
    t_vl = 1; t_all = 0; t_bo = 4'b0000;
    start = 1'b1;
    @(negedge clk); a_cyc++;
    start = 1'b0;
    while (!done && a_cyc < 400) begin
      @(negedge clk);
      a_cyc++;
    end
    chk("R12", "busy start ignored cycles", 64'(a_cyc), 6);
    chk("R12", "busy start ignored taken", 64'(taken), 64'(e_taken));
    chk("R12", "busy start ignored count", ctr_out, 64'(e_ctr));
    t_ctr = 64'h55; t_all = 1;
    repeat (3) @(negedge clk);
    chk("R12", "done single cycle", 64'(done), 0);
    chk("R12", "result holds", {ctr_out[62:0], taken}, {e_ctr[62:0], e_taken});

    // sweep
    for (int k = 0; k < 900; k++) begin
      if (k % 40 == 0) fill_mem();
      rand_cfg();
      run();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule